// File: doc/BRIEF.md
# Coincidence cluster reduction encoder

This block sits after a coincidence matrix. The matrix delivers a hit map with one row for each deviation value and one column for each output channel. For every channel, the block keeps only the candidate with the smallest absolute deviation. It then treats each run of neighbouring hit channels as one track and reduces the run to a single channel. Finally it reports the surviving track as a channel position and a signed deviation.

The channel range is built as two equal halves, and each half is declustered on its own. A run that crosses the seam between the halves is joined there, so that a single track never produces two clusters. If more than one cluster survives, the block reports the one at the lowest channel index and raises an overflow flag. Results are registered. A hit map sampled on one clock edge appears at the outputs after the following edge, which keeps the block well inside a budget of four 25 ns periods.

Top module: `cluster_reduce_enc`

## Requirements
- R1: While reset is held, and after reset until a sampled hit map has passed through the pipeline, trkValid, trkPos, trkDev and trkOverflow are all zero.
- R2: A hit map sampled on clock edge n produces its result on the outputs after edge n+1. The outputs after edge n still show the previous result.
- R3: Bit r*NCH+c of hitMap marks a hit on channel c with deviation r-DEVMAX. For each channel the candidate with the smallest absolute deviation is kept. trkDev carries it in two's complement, so with the defaults it lies in -3..+3 and never takes the code 3'b100.
- R4: When a channel holds two candidates of equal magnitude, the positive deviation is kept.
- R5: A run of adjacent hit channels is reduced to its lowest-index channel, whatever their deviations are. trkPos is that channel, and trkDev is the deviation selected on that channel.
- R6: A run that covers both channel NCH/2-1 and channel NCH/2 is one cluster. It reports no overflow and is represented by its lowest channel.
- R7: When two or more clusters survive, trkPos and trkDev describe the cluster with the lowest channel index and trkOverflow is 1.
- R8: With no hit in the map, trkValid is 0 and trkPos, trkDev and trkOverflow are driven to zero.
- R9: trkOverflow is never 1 while trkValid is 0.
- R10: Hit maps presented on consecutive cycles produce independent results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hitMap | input | NDEV*NCH (224) | Coincidence hit map, deviation row major |
| trkValid | output | 1 | At least one cluster survived |
| trkPos | output | POSW (5) | Lowest-index cluster position |
| trkDev | output | DEVW (3) | Deviation of the reported cluster, two's complement |
| trkOverflow | output | 1 | More than one cluster survived |

## Verification
Single hits at several channels establish the position encoding. Channels that carry two or more candidates separate the magnitude rule from the sign tie rule, and show whether the row-to-deviation mapping is off by one. Runs placed inside one half, across the seam, ending at the top channel, and separated by a single-channel gap separate correct declustering from double counting and from merging clusters that should stay apart. Pairs of separated clusters show that the lowest index wins and that overflow is raised. Back-to-back maps and a one-cycle look before the result confirm the fixed latency.

// File: rtl/cre_pkg.sv
package cre_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadPrio;  // capture per-channel selection
    logic loadOut;   // capture encoded result
  } ctrlStrobes_t;

endpackage

// File: rtl/cre_prio.sv
// Per-channel minimum-deviation selection.
// Search order: 0, +1, -1, +2, -2, ... so a positive value wins a magnitude tie.
module cre_prio #(
  parameter int DEVMAX = 3,
  parameter int NDEV   = 2*DEVMAX+1,
  parameter int DEVW   = $clog2(DEVMAX+1)+1
) (
  input  logic [NDEV-1:0] col,
  output logic            chHit,
  output logic [DEVW-1:0] chDev
);

  always_comb begin
    chHit = 1'b0;
    chDev = {1'b1, {(DEVW-1){1'b0}}};  // reserved no-hit code
    // walk from lowest to highest priority; the last match wins
    for (int k = NDEV-1; k >= 0; k--) begin
      int mag;
      int dev;
      mag = (k + 1) / 2;
      dev = ((k % 2) == 1) ? mag : -mag;
      if (col[dev + DEVMAX]) begin
        chHit = 1'b1;
        chDev = DEVW'(dev);
      end
    end
  end

endmodule

// File: rtl/cre_datapath.sv
// Selection stage, split-half declustering, and the output encoder.
module cre_datapath
  import cre_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int DEVMAX = 3,
  parameter int NDEV   = 2*DEVMAX+1,
  parameter int DEVW   = $clog2(DEVMAX+1)+1,
  parameter int POSW   = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [NDEV*NCH-1:0]  hitMap,
  output logic                 trkValid,
  output logic [POSW-1:0]      trkPos,
  output logic [DEVW-1:0]      trkDev,
  output logic                 trkOverflow
);

  localparam int HALF = NCH / 2;

  // ---------- stage 1: per-channel primary selection ----------
  logic [NCH-1:0]  chHitD;
  logic [DEVW-1:0] chDevD [NCH];
  logic [NCH-1:0]  chHitQ;
  logic [DEVW-1:0] chDevQ [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [NDEV-1:0] col;
    for (genvar r = 0; r < NDEV; r++) begin : g_row
      assign col[r] = hitMap[r*NCH + c];
    end
    cre_prio #(.DEVMAX(DEVMAX), .NDEV(NDEV), .DEVW(DEVW)) u_prio (
      .col   (col),
      .chHit (chHitD[c]),
      .chDev (chDevD[c])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chHitQ[c] <= 1'b0;
        chDevQ[c] <= '0;
      end else if (strobes.loadPrio) begin
        chHitQ[c] <= chHitD[c];
        chDevQ[c] <= chDevD[c];
      end
    end
  end

  // ---------- declustering per half, then seam merge ----------
  logic [NCH-1:0] localStart;
  logic           seamJoin;
  logic [NCH-1:0] clusStart;

  for (genvar i = 0; i < NCH; i++) begin : g_dclu
    if ((i % HALF) == 0) begin : g_first
      assign localStart[i] = chHitQ[i];
    end else begin : g_inner
      assign localStart[i] = chHitQ[i] & ~chHitQ[i-1];
    end
  end

  // a run that crosses the seam keeps only the start found in the lower half
  assign seamJoin = chHitQ[HALF-1] & chHitQ[HALF];

  always_comb begin
    clusStart       = localStart;
    clusStart[HALF] = localStart[HALF] & ~seamJoin;
  end

  // ---------- encoder ----------
  logic [POSW-1:0] posD;
  logic            anyD;
  logic            multiD;

  always_comb begin
    posD = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (clusStart[i]) posD = POSW'(i);
    end
  end

  assign anyD   = |clusStart;
  assign multiD = |(clusStart & (clusStart - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trkValid    <= 1'b0;
      trkPos      <= '0;
      trkDev      <= '0;
      trkOverflow <= 1'b0;
    end else if (strobes.loadOut) begin
      trkValid    <= anyD;
      trkPos      <= anyD ? posD : '0;
      trkDev      <= anyD ? chDevQ[posD] : '0;
      trkOverflow <= anyD & multiD;
    end
  end

endmodule

// File: rtl/cre_ctrl.sv
// Pipeline control: stage 1 loads whenever out of reset; the output stage
// loads from the edge after stage 1 first holds a real sample.
module cre_ctrl
  import cre_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t strobes
);

  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  always_comb begin
    strobes.loadPrio = 1'b1;
    strobes.loadOut  = primed;
  end

endmodule

// File: rtl/cluster_reduce_enc.sv
module cluster_reduce_enc
  import cre_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int DEVMAX = 3,
  localparam int NDEV  = 2*DEVMAX+1,
  localparam int DEVW  = $clog2(DEVMAX+1)+1,
  localparam int POSW  = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NDEV*NCH-1:0] hitMap,
  output logic                trkValid,
  output logic [POSW-1:0]     trkPos,
  output logic [DEVW-1:0]     trkDev,
  output logic                trkOverflow
);

  ctrlStrobes_t strobes;

  cre_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  cre_datapath #(
    .NCH(NCH), .DEVMAX(DEVMAX), .NDEV(NDEV), .DEVW(DEVW), .POSW(POSW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .hitMap      (hitMap),
    .trkValid    (trkValid),
    .trkPos      (trkPos),
    .trkDev      (trkDev),
    .trkOverflow (trkOverflow)
  );

endmodule

// File: rtl/cre_checker.sv
module cre_checker #(
  parameter int NCH  = 32,
  parameter int NDEV = 7,
  parameter int DEVW = 3,
  parameter int POSW = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic [NDEV*NCH-1:0] hitMap,
  input logic                trkValid,
  input logic [POSW-1:0]     trkPos,
  input logic [DEVW-1:0]     trkDev,
  input logic                trkOverflow
);

  // counts edges since reset so that two-cycle history is only used when real
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_clear_r1: assert (!trkValid && trkPos == '0 && trkDev == '0 && !trkOverflow)
        else $error("outputs not clear in reset");
    end
  end

  // R8
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !trkValid |-> (trkPos == '0 && trkDev == '0 && !trkOverflow));

  // R9
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    trkOverflow |-> trkValid);

  // R3: the reserved code never leaves the block with a track
  p_dev_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    trkValid |-> trkDev != {1'b1, {(DEVW-1){1'b0}}});

  // R2: any hit two edges back yields a track now
  p_hit_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2 && $past(|hitMap, 2)) |-> trkValid);

  // R8: an empty map two edges back yields no track now
  p_empty_map_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2 && $past(hitMap == '0, 2)) |-> !trkValid);

endmodule

bind cluster_reduce_enc cre_checker #(
  .NCH(NCH), .NDEV(NDEV), .DEVW(DEVW), .POSW(POSW)
) u_chk (
  .clk(clk), .rstN(rstN), .hitMap(hitMap), .trkValid(trkValid),
  .trkPos(trkPos), .trkDev(trkDev), .trkOverflow(trkOverflow)
);

// File: tb/sim_cluster_reduce_enc.sv
module sim_cluster_reduce_enc;

  localparam int NCH  = 32;
  localparam int NDEV = 7;
  localparam int MW   = NDEV*NCH;

  // one hit spec: run of len channels from ch, all at deviation dev
  typedef struct packed {
    logic              en;
    logic [4:0]        ch;
    logic signed [2:0] dev;
    logic [2:0]        len;
  } spec_t;

  typedef struct packed {
    spec_t      a;
    spec_t      b;
    spec_t      c;
    logic       v;
    logic [4:0] p;
    logic [2:0] d;
    logic       o;
  } vec_t;

  function automatic spec_t hs(int c, int d, int l);
    hs = {1'b1, 5'(c), 3'(d), 3'(l)};
  endfunction

  localparam spec_t NS = '0;
  localparam int NVEC = 14;

  localparam vec_t VECS [NVEC] = '{
    '{NS,             NS,             NS,            1'b0, 5'd0,  3'b000, 1'b0}, // R8 empty
    '{hs(7,0,1),      NS,             NS,            1'b1, 5'd7,  3'b000, 1'b0}, // R3 single
    '{hs(7,-2,1),     hs(7,3,1),      NS,            1'b1, 5'd7,  3'b110, 1'b0}, // R3 min mag
    '{hs(10,-1,1),    hs(10,1,1),     NS,            1'b1, 5'd10, 3'b001, 1'b0}, // R4 tie
    '{hs(3,3,1),      hs(3,-3,1),     NS,            1'b1, 5'd3,  3'b011, 1'b0}, // R4 tie
    '{hs(20,-1,4),    NS,             NS,            1'b1, 5'd20, 3'b111, 1'b0}, // R5 run
    '{hs(14,2,4),     NS,             NS,            1'b1, 5'd14, 3'b010, 1'b0}, // R6 seam run
    '{hs(15,0,1),     hs(16,-3,1),    NS,            1'b1, 5'd15, 3'b000, 1'b0}, // R6 seam pair
    '{hs(25,1,1),     hs(4,-2,1),     NS,            1'b1, 5'd4,  3'b110, 1'b1}, // R7
    '{hs(15,0,1),     hs(17,1,1),     NS,            1'b1, 5'd15, 3'b000, 1'b1}, // R7 gap
    '{hs(0,-3,7),     hs(31,2,1),     NS,            1'b1, 5'd0,  3'b101, 1'b1}, // R7 edges
    '{hs(31,-1,1),    NS,             NS,            1'b1, 5'd31, 3'b111, 1'b0}, // R3 top ch
    '{hs(8,2,1),      hs(9,0,1),      hs(10,-1,1),   1'b1, 5'd8,  3'b010, 1'b0}, // R5 rep dev
    '{hs(28,3,4),     hs(12,1,1),     hs(13,-1,2),   1'b1, 5'd12, 3'b001, 1'b1}  // R7 R5
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [MW-1:0] hitMap = '0;
  logic          trkValid;
  logic [4:0]    trkPos;
  logic [2:0]    trkDev;
  logic          trkOverflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cluster_reduce_enc u0 (
    .clk(clk), .rstN(rstN), .hitMap(hitMap), .trkValid(trkValid),
    .trkPos(trkPos), .trkDev(trkDev), .trkOverflow(trkOverflow)
  );

  function automatic logic [MW-1:0] buildMap(vec_t v);
    spec_t s [3];
    logic [MW-1:0] m;
    m = '0;
    s[0] = v.a; s[1] = v.b; s[2] = v.c;
    for (int i = 0; i < 3; i++) begin
      if (s[i].en) begin
        for (int k = 0; k < int'(s[i].len); k++) begin
          m[(int'(s[i].dev) + 3)*NCH + int'(s[i].ch) + k] = 1'b1;
        end
      end
    end
    return m;
  endfunction

  function automatic logic [MW-1:0] oneHit(int c, int d);
    logic [MW-1:0] m;
    m = '0;
    m[(d + 3)*NCH + c] = 1'b1;
    return m;
  endfunction

  // compare {valid,pos,dev,ovf}
  task automatic chk(string req, logic [9:0] exp);
    logic [9:0] act;
    act = {trkValid, trkPos, trkDev, trkOverflow};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual v=%0b p=%0d d=%b o=%0b expected v=%0b p=%0d d=%b o=%0b",
               req, act[9], act[8:4], act[3:1], act[0], exp[9], exp[8:4], exp[3:1], exp[0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: during reset, with a busy map
    hitMap = buildMap(VECS[1]);
    repeat (3) @(negedge clk);
    chk("R1 in reset", 10'b0);
    hitMap = '0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", 10'b0);
    @(negedge clk);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      hitMap = buildMap(VECS[i]);
      @(negedge clk);
      @(negedge clk);
      chk($sformatf("vector %0d (R3 R4 R5 R6 R7 R8)", i),
          {VECS[i].v, VECS[i].p, VECS[i].d, VECS[i].o});
    end

    // R2: one cycle after sampling the old result is still present
    hitMap = '0;
    @(negedge clk); @(negedge clk);
    hitMap = oneHit(9, 0);
    @(negedge clk);
    hitMap = '0;
    chk("R2 before latency", 10'b0);
    @(negedge clk);
    chk("R2 at latency", {1'b1, 5'd9, 3'b000, 1'b0});
    @(negedge clk);
    chk("R8 back to idle", 10'b0);

    // R10: back-to-back maps
    hitMap = oneHit(2, 1);
    @(negedge clk);
    hitMap = oneHit(30, -2) | oneHit(5, 3);
    @(negedge clk);
    hitMap = oneHit(18, -1);
    chk("R10 first", {1'b1, 5'd2, 3'b001, 1'b0});
    @(negedge clk);
    hitMap = '0;
    chk("R10 second", {1'b1, 5'd5, 3'b011, 1'b1});
    @(negedge clk);
    chk("R10 third", {1'b1, 5'd18, 3'b111, 1'b0});

    // R1: reset in the middle of traffic clears the outputs
    hitMap = oneHit(11, 2);
    @(negedge clk); @(negedge clk);
    chk("R5 before reset", {1'b1, 5'd11, 3'b010, 1'b0});
    rstN = 1'b0;
    #1;
    chk("R1 async clear", 10'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 first cycle after reset", 10'b0);
    hitMap = '0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule